// File: doc/BRIEF.md
# Menu-Driven SPI Flash Cycle Sequencer

The sequencer runs one complete SPI flash cycle each time the host writes a control word with its start bit set. The host never hands over an opcode directly. It loads an eight-entry opcode menu and a table holding a two-bit cycle type for each entry. The control word then names one entry by index, gives the data byte count, and sets the options. The engine builds the serial frame from the chosen entry: opcode, an optional 24-bit address and optional data bytes. It shifts the frame out in SPI mode 0, MSB first, with chip select held low for the whole frame. Bytes read back are stored in the 64-byte data buffer.

The control word can ask for an atomic prefix. In that case the byte held in the prefix register (typically a write-enable opcode) goes out first as its own chip-select frame, and the main frame follows after a short deselect gap. A one-way lock bit freezes the menu, the type table and the prefix register until reset. A speed bit selects between a slow and a fast SCK rate.

Host register map (6-bit word address, 32-bit data):

| Address | Contents |
|---|---|
| 0x00 | control word (write only) |
| 0x01 | status |
| 0x02 | flash address |
| 0x03 | type table |
| 0x04 | menu entries 0 to 3 (entry n at bits 8n+7:8n) |
| 0x05 | menu entries 4 to 7 |
| 0x06 | prefix opcode |
| 0x07 | lock |
| 0x20 to 0x2F | data buffer |

Top module: `spi_flash_seq`

## Requirements
- R1: After reset the status register (0x01) reads 0, chip select is high and SCK is low.
- R2: The opcode sent is the menu entry picked by control bits 6:4. Each entry's type is read from the type table (0x03) at bits 2n+1:2n. Type codes: 0 is read without address, 1 is write without address, 2 is read with address, 3 is write with address. Bit 0 of the type code marks a write and bit 1 marks an address.
- R3: A frame is sent in SPI mode 0, MSB first. It carries the opcode, then three address bytes (most significant first) only for address types, then the data bytes. Chip select stays low from the first bit to the last.
- R4: The flash address register keeps 24 bits. Bits written above bit 23 are dropped and read back as 0.
- R5: Control bits 13:8 hold the data byte count minus one. Data bytes are sent only when control bit 14 is set. A write sends buffer byte j, which is held in word 0x20+j/4 at bits 8*(j%4)+7:8*(j%4).
- R6: On a read type with data, the j-th byte received after the header is stored in buffer byte j.
- R7: A control write with bit 0 set starts a cycle. Status bit 0 (busy) reads 1 from the clock after that write until the frame has ended.
- R8: Status bit 1 (done) is set when a cycle completes. Writing 1 to bit 1 or bit 2 of the status register clears that bit.
- R9: A start of a read type with control bit 14 clear is rejected. The engine sets status bit 2 (error), never goes busy and sends no frame.
- R10: With control bit 2 set, the prefix register (0x06) is sent as a one-byte frame of its own, chip select goes high, and the main frame follows.
- R11: After 1 is written to bit 0 of the lock register (0x07), writes to the menu, the type table and the prefix register have no effect until reset.
- R12: The SCK period is 2*SLOW_HALF clocks when control bit 15 is clear and 2*FAST_HALF clocks when it is set.
- R13: A start written while a cycle is in progress is ignored. The running cycle completes unchanged and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| reg_we_i | input | 1 | register write strobe |
| reg_addr_i | input | 6 | register word address |
| reg_wdata_i | input | 32 | register write data |
| reg_rdata_o | output | 32 | read data for reg_addr_i (combinational) |
| spi_cs_no | output | 1 | flash chip select, active low |
| spi_sck_o | output | 1 | serial clock |
| spi_mosi_o | output | 1 | serial data to flash |
| spi_miso_i | input | 1 | serial data from flash |

## Verification
A register write takes effect at the clock edge that samples it. Read data is combinational, so a readback taken just after the write's edge, away from the edge, already shows the new value. Busy, or the error flag for a rejected start, is therefore checked in the first half-cycle after the start write, while the frame is still far from finished. Frame completion is not tied to a fixed cycle count. The bench polls status once per clock until busy drops, then checks the flags. A slave model captures every MOSI bit on the SCK rising edge and serves known MISO bytes, so frame content and stored read data are checked by position within the frame. The SCK period is measured between two rising edges inside one byte.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam logic [5:0] RA_CTRL    = 6'h00;
  localparam logic [5:0] RA_STATUS  = 6'h01;
  localparam logic [5:0] RA_ADDR    = 6'h02;
  localparam logic [5:0] RA_TYPES   = 6'h03;
  localparam logic [5:0] RA_MENU_LO = 6'h04;
  localparam logic [5:0] RA_MENU_HI = 6'h05;
  localparam logic [5:0] RA_PREFIX  = 6'h06;
  localparam logic [5:0] RA_LOCK    = 6'h07;
  localparam logic [5:0] RA_BUF     = 6'h20;

  localparam int CTL_GO   = 0;
  localparam int CTL_ATOM = 2;
  localparam int CTL_IDX  = 4;
  localparam int CTL_CNT  = 8;
  localparam int CTL_DPH  = 14;
  localparam int CTL_FAST = 15;

  localparam int STS_BUSY = 0;
  localparam int STS_DONE = 1;
  localparam int STS_ERR  = 2;

  localparam int TY_WR  = 0;
  localparam int TY_ADR = 1;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_GAP, S_MAIN, S_FIN} seq_state_e;
endpackage

// File: rtl/seq_byte_shifter.sv
module seq_byte_shifter #(
  parameter int SLOW_HALF = 3,
  parameter int FAST_HALF = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       fast_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  localparam int HC_W = $clog2(SLOW_HALF + 1);

  logic            act_q, sck_q, done_q;
  logic [HC_W-1:0] cnt_q, half;
  logic [2:0]      bit_q;
  logic [7:0]      sh_q, rx_q;

  assign half = fast_i ? HC_W'(FAST_HALF) : HC_W'(SLOW_HALF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0; sck_q <= 1'b0; done_q <= 1'b0;
      cnt_q <= '0; bit_q <= '0; sh_q <= '0; rx_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        act_q <= 1'b1; sh_q <= tx_i; sck_q <= 1'b0;
        cnt_q <= '0; bit_q <= '0;
      end else if (act_q) begin
        if (cnt_q == half - HC_W'(1)) begin
          cnt_q <= '0;
          if (!sck_q) begin
            sck_q <= 1'b1;
            rx_q  <= {rx_q[6:0], miso_i};
          end else begin
            sck_q <= 1'b0;
            if (bit_q == 3'd7) begin
              act_q  <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 3'd1;
              sh_q  <= {sh_q[6:0], 1'b0};
            end
          end
        end else begin
          cnt_q <= cnt_q + HC_W'(1);
        end
      end
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = sh_q[7];
  assign done_o = done_q;
  assign rx_o   = rx_q;

  // R3
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !act_q);
endmodule

// File: rtl/seq_reg_file.sv
module seq_reg_file
  import spi_seq_pkg::*;
#(
  parameter int BUF_BYTES = 64
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [5:0]                   addr_i,
  input  logic [31:0]                  wdata_i,
  output logic [31:0]                  rdata_o,
  input  logic [2:0]                   status_i,
  output logic [63:0]                  menu_o,
  output logic [15:0]                  types_o,
  output logic [7:0]                   prefix_o,
  output logic [23:0]                  faddr_o,
  output logic [BUF_BYTES*8-1:0]       buf_flat_o,
  input  logic                         eng_we_i,
  input  logic [$clog2(BUF_BYTES)-1:0] eng_idx_i,
  input  logic [7:0]                   eng_data_i
);
  localparam int IDX_W     = $clog2(BUF_BYTES);
  localparam int BUF_WORDS = BUF_BYTES / 4;
  localparam int WRD_W     = $clog2(BUF_WORDS);

  logic [63:0] menu_q;
  logic [15:0] types_q;
  logic [7:0]  prefix_q;
  logic [23:0] faddr_q;
  logic        lock_q;
  logic        in_buf, host_buf_we;
  logic [WRD_W-1:0] host_word;

  assign in_buf      = (addr_i >= RA_BUF) && (addr_i < RA_BUF + 6'(BUF_WORDS));
  assign host_buf_we = we_i && in_buf;
  assign host_word   = WRD_W'(addr_i - RA_BUF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      menu_q <= '0; types_q <= '0; prefix_q <= '0; faddr_q <= '0; lock_q <= 1'b0;
    end else if (we_i) begin
      case (addr_i)
        RA_ADDR:    faddr_q <= wdata_i[23:0];
        RA_TYPES:   if (!lock_q) types_q <= wdata_i[15:0];
        RA_MENU_LO: if (!lock_q) menu_q[31:0] <= wdata_i;
        RA_MENU_HI: if (!lock_q) menu_q[63:32] <= wdata_i;
        RA_PREFIX:  if (!lock_q) prefix_q <= wdata_i[7:0];
        RA_LOCK:    if (wdata_i[0]) lock_q <= 1'b1;
        default: ;
      endcase
    end
  end

  for (genvar b = 0; b < BUF_BYTES; b++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) byte_q <= '0;
      else if (eng_we_i && eng_idx_i == IDX_W'(b)) byte_q <= eng_data_i;
      else if (host_buf_we && host_word == WRD_W'(b / 4)) byte_q <= wdata_i[8*(b%4) +: 8];
    end
    assign buf_flat_o[8*b +: 8] = byte_q;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_STATUS:  rdata_o = {29'b0, status_i};
      RA_ADDR:    rdata_o = {8'b0, faddr_q};
      RA_TYPES:   rdata_o = {16'b0, types_q};
      RA_MENU_LO: rdata_o = menu_q[31:0];
      RA_MENU_HI: rdata_o = menu_q[63:32];
      RA_PREFIX:  rdata_o = {24'b0, prefix_q};
      RA_LOCK:    rdata_o = {31'b0, lock_q};
      default:    if (in_buf) rdata_o = buf_flat_o[32*int'(host_word) +: 32];
    endcase
  end

  assign menu_o   = menu_q;
  assign types_o  = types_q;
  assign prefix_o = prefix_q;
  assign faddr_o  = faddr_q;

  // R11
  lock_menu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q && we_i && (addr_i == RA_MENU_LO) |=> $stable(menu_q[31:0]));
endmodule

// File: rtl/spi_flash_seq.sv
module spi_flash_seq
  import spi_seq_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  parameter int SLOW_HALF = 3,
  parameter int FAST_HALF = 2,
  parameter int GAP_CYC   = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [5:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        spi_cs_no,
  output logic        spi_sck_o,
  output logic        spi_mosi_o,
  input  logic        spi_miso_i
);
  localparam int IDX_W = $clog2(BUF_BYTES);
  localparam int POS_W = $clog2(BUF_BYTES + 5);
  localparam int GAP_W = $clog2(GAP_CYC + 1);

  seq_state_e state_q;
  logic [63:0] menu;
  logic [15:0] types;
  logic [7:0]  prefix, tx_byte, rx_byte, op_q;
  logic [23:0] faddr, addr_q;
  logic [BUF_BYTES*8-1:0] buf_flat;
  logic [1:0]  typ_q, sel_type;
  logic [IDX_W-1:0] cnt_q, data_idx;
  logic [POS_W-1:0] pos_q, hdr_len, data_len, last_pos;
  logic [GAP_W-1:0] gap_q;
  logic [2:0]  sel_idx, status;
  logic dph_q, fast_q, atom_q, kick_q, cs_n_q, done_q, err_q;
  logic go_req, sts_wr, reject, sh_done, busy, eng_we;

  assign go_req   = reg_we_i && (reg_addr_i == RA_CTRL) && reg_wdata_i[CTL_GO];
  assign sts_wr   = reg_we_i && (reg_addr_i == RA_STATUS);
  assign sel_idx  = reg_wdata_i[CTL_IDX +: 3];
  assign sel_type = types[{sel_idx, 1'b0} +: 2];
  // a read cycle with nothing to read is meaningless
  assign reject   = !reg_wdata_i[CTL_DPH] && !sel_type[TY_WR];
  assign busy     = (state_q != S_IDLE);
  assign status   = {err_q, done_q, busy};

  assign hdr_len  = typ_q[TY_ADR] ? POS_W'(4) : POS_W'(1);
  assign data_len = dph_q ? POS_W'(cnt_q) + POS_W'(1) : '0;
  assign last_pos = hdr_len + data_len - POS_W'(1);
  assign data_idx = IDX_W'(pos_q - hdr_len);
  assign eng_we   = (state_q == S_MAIN) && sh_done && (pos_q >= hdr_len) && !typ_q[TY_WR];

  always_comb begin
    if (state_q == S_PRE)   tx_byte = prefix;
    else if (pos_q == '0)   tx_byte = op_q;
    else if (pos_q < hdr_len) begin
      case (pos_q[1:0])
        2'd1:    tx_byte = addr_q[23:16];
        2'd2:    tx_byte = addr_q[15:8];
        default: tx_byte = addr_q[7:0];
      endcase
    end else tx_byte = typ_q[TY_WR] ? buf_flat[{data_idx, 3'b000} +: 8] : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; pos_q <= '0; gap_q <= '0; kick_q <= 1'b0; cs_n_q <= 1'b1;
      done_q <= 1'b0; err_q <= 1'b0; op_q <= '0; typ_q <= '0; cnt_q <= '0;
      dph_q <= 1'b0; fast_q <= 1'b0; atom_q <= 1'b0; addr_q <= '0;
    end else begin
      kick_q <= 1'b0;
      if (sts_wr && reg_wdata_i[STS_DONE]) done_q <= 1'b0;
      if (sts_wr && reg_wdata_i[STS_ERR])  err_q  <= 1'b0;
      case (state_q)
        S_IDLE: if (go_req) begin
          if (reject) err_q <= 1'b1;
          else begin
            op_q   <= menu[{sel_idx, 3'b000} +: 8];
            typ_q  <= sel_type;
            cnt_q  <= reg_wdata_i[CTL_CNT +: IDX_W];
            dph_q  <= reg_wdata_i[CTL_DPH];
            fast_q <= reg_wdata_i[CTL_FAST];
            atom_q <= reg_wdata_i[CTL_ATOM];
            addr_q <= faddr;
            pos_q  <= '0;
            cs_n_q <= 1'b0;
            kick_q <= 1'b1;
            state_q <= reg_wdata_i[CTL_ATOM] ? S_PRE : S_MAIN;
          end
        end
        S_PRE: if (sh_done) begin
          cs_n_q <= 1'b1; gap_q <= '0; state_q <= S_GAP;
        end
        S_GAP: begin
          gap_q <= gap_q + GAP_W'(1);
          if (gap_q == GAP_W'(GAP_CYC - 1)) begin
            cs_n_q <= 1'b0; kick_q <= 1'b1; state_q <= S_MAIN;
          end
        end
        S_MAIN: if (sh_done) begin
          if (pos_q == last_pos) begin
            cs_n_q <= 1'b1; state_q <= S_FIN;
          end else begin
            pos_q <= pos_q + POS_W'(1); kick_q <= 1'b1;
          end
        end
        S_FIN: begin
          done_q <= 1'b1; state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  seq_reg_file #(.BUF_BYTES(BUF_BYTES)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .status_i(status), .menu_o(menu), .types_o(types), .prefix_o(prefix), .faddr_o(faddr),
    .buf_flat_o(buf_flat), .eng_we_i(eng_we), .eng_idx_i(data_idx), .eng_data_i(rx_byte)
  );

  seq_byte_shifter #(.SLOW_HALF(SLOW_HALF), .FAST_HALF(FAST_HALF)) u_shift (
    .clk_i, .rst_ni, .start_i(kick_q), .fast_i(fast_q), .tx_i(tx_byte),
    .miso_i(spi_miso_i), .sck_o(spi_sck_o), .mosi_o(spi_mosi_o), .done_o(sh_done), .rx_o(rx_byte)
  );

  assign spi_cs_no = cs_n_q;

  // R3
  sck_framed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sck_o);
  // R9
  reject_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_req && !busy && reject |=> !busy && err_q);
  // R13
  busy_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_req && busy |=> $stable(op_q) && $stable(cnt_q) && $stable(typ_q));
  // R8
  finish_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_FIN |=> !busy && done_q);
endmodule

// File: tb/sim_spi_flash_seq.sv
module sim_spi_flash_seq;
  localparam logic [5:0] A_CTRL = 6'h00, A_STS = 6'h01, A_ADDR = 6'h02, A_TYPES = 6'h03;
  localparam logic [5:0] A_MLO = 6'h04, A_MHI = 6'h05, A_PRE = 6'h06, A_LOCK = 6'h07, A_BUF = 6'h20;
  localparam int SLOW = 3, FAST = 2;
  localparam logic [15:0] TYPES = 16'h4E4E;
  localparam logic [7:0] MENU [8] = '{8'h03, 8'h02, 8'h05, 8'h06, 8'h0B, 8'h20, 8'h9F, 8'hD8};
  // {fast, atom, cnt-1, dph, idx}
  localparam logic [11:0] VEC [6] = '{
    {1'b0, 1'b0, 6'd0,  1'b1, 3'd2},
    {1'b1, 1'b0, 6'd3,  1'b1, 3'd0},
    {1'b0, 1'b1, 6'd2,  1'b1, 3'd1},
    {1'b0, 1'b0, 6'd0,  1'b0, 3'd3},
    {1'b0, 1'b0, 6'd0,  1'b0, 3'd6},
    {1'b1, 1'b1, 6'd63, 1'b1, 3'd5}};

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic cs_n, sck, mosi, miso;
  int errs = 0, total = 0;

  always #2 clk = ~clk;

  spi_flash_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .spi_cs_no(cs_n), .spi_sck_o(sck), .spi_mosi_o(mosi), .spi_miso_i(miso));

  // flash model: captures MOSI on SCK rise, serves byte k of a frame as 5A^k
  int bitc = 0, fr_cnt = 0;
  int fr_len [2];
  logic [7:0] shin = '0;
  logic [7:0] cap [2][80];
  logic [7:0] rb;
  time t_prev = 0, per = 0;
  assign rb   = 8'h5A ^ 8'(bitc / 8);
  assign miso = rb[3'd7 - 3'(bitc % 8)];

  always @(negedge cs_n) bitc = 0;
  always @(posedge sck) begin
    shin = {shin[6:0], mosi};
    if (bitc % 8 == 7 && fr_cnt < 2 && bitc / 8 < 80) cap[fr_cnt][bitc/8] = shin;
    if (bitc % 8 != 0) per = $time - t_prev;
    t_prev = $time;
    bitc++;
  end
  always @(posedge cs_n) if (bitc > 0) begin
    if (fr_cnt < 2) fr_len[fr_cnt] = bitc / 8;
    fr_cnt++;
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk); rd(A_STS, s);
      if (!s[0]) break;
    end
  endtask

  task automatic load_buf();
    for (int w = 0; w < 16; w++)
      wr(A_BUF + 6'(w), {8'(4*w+3) ^ 8'hC3, 8'(4*w+2) ^ 8'hC3, 8'(4*w+1) ^ 8'hC3, 8'(4*w) ^ 8'hC3});
  endtask

  function automatic logic [31:0] ctl(input logic [11:0] v);
    return {16'h0, v[11], v[3], v[9:4], 1'b0, v[2:0], 1'b0, v[10], 2'b01};
  endfunction

  task automatic program_cfg();
    wr(A_MLO, 32'h06050203);
    wr(A_MHI, 32'hD89F200B);
    wr(A_TYPES, {16'h0, TYPES});
    wr(A_PRE, 32'h06);
    wr(A_ADDR, 32'h12345678);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; total++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

  initial begin
    logic [31:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(A_STS, s);
    chk(s == 0 && cs_n && !sck, "R1 reset state", {s[29:0], cs_n, sck}, 32'h2);

    program_cfg();
    rd(A_ADDR, s);
    chk(s == 32'h00345678, "R4 address readback", s, 32'h00345678);

    for (int v = 0; v < 6; v++) begin
      logic [11:0] vv;
      logic [1:0] ty;
      bit rej, ok;
      int hdr, m, n, efc;
      vv  = VEC[v];
      ty  = TYPES[2*vv[2:0] +: 2];
      rej = !vv[3] && !ty[0];
      hdr = ty[1] ? 4 : 1;
      n   = hdr + (vv[3] ? int'(vv[9:4]) + 1 : 0);
      load_buf();
      wr(A_STS, 32'h6);
      fr_cnt = 0;
      wr(A_CTRL, ctl(vv));
      rd(A_STS, s);
      if (rej) chk(s == 32'h4, "R9 rejected start flags", s, 32'h4);
      else     chk(s[0] == 1'b1, "R7 busy after start", s, 32'h1);
      wait_idle();
      rd(A_STS, s);
      chk(s == (rej ? 32'h4 : 32'h2), rej ? "R9 final status" : "R8 done flag", s, rej ? 32'h4 : 32'h2);
      efc = rej ? 0 : (vv[10] ? 2 : 1);
      chk(fr_cnt == efc, "R10 frame count", 32'(fr_cnt), 32'(efc));
      if (rej || fr_cnt != efc) continue;
      if (vv[10])
        chk(fr_len[0] == 1 && cap[0][0] == 8'h06, "R10 prefix frame", {cap[0][0], 24'(fr_len[0])}, {8'h06, 24'd1});
      m = vv[10] ? 1 : 0;
      chk(fr_len[m] == n, "R5 frame length", 32'(fr_len[m]), 32'(n));
      chk(cap[m][0] == MENU[vv[2:0]], "R2 opcode from menu", 32'(cap[m][0]), 32'(MENU[vv[2:0]]));
      if (ty[1])
        chk({cap[m][1], cap[m][2], cap[m][3]} == 24'h345678, "R3 address bytes",
            {8'h0, cap[m][1], cap[m][2], cap[m][3]}, 32'h00345678);
      if (ty[0] && vv[3]) begin
        ok = 1'b1;
        for (int j = 0; j < n - hdr; j++) if (cap[m][hdr+j] != (8'(j) ^ 8'hC3)) ok = 1'b0;
        chk(ok, "R5 write data bytes", 32'(ok), 32'h1);
      end
      if (!ty[0]) begin
        ok = 1'b1;
        for (int w = 0; w < 16; w++) begin
          rd(A_BUF + 6'(w), s);
          for (int k = 0; k < 4; k++) begin
            int j;
            logic [7:0] e;
            j = 4*w + k;
            e = (j < n - hdr) ? (8'h5A ^ 8'(hdr + j)) : (8'(j) ^ 8'hC3);
            if (s[8*k +: 8] != e) ok = 1'b0;
          end
        end
        chk(ok, "R6 read data stored", 32'(ok), 32'h1);
      end
      chk(per == time'(2 * (vv[11] ? FAST : SLOW) * 4), "R12 sck period", 32'(per),
          32'(2 * (vv[11] ? FAST : SLOW) * 4));
    end

    // R8 write-one-to-clear
    wr(A_STS, 32'h2);
    rd(A_STS, s);
    chk(s == 0, "R8 done cleared", s, 32'h0);

    // R13 start while busy
    load_buf();
    fr_cnt = 0;
    wr(A_CTRL, ctl({1'b0, 1'b0, 6'd63, 1'b1, 3'd5}));
    wr(A_CTRL, ctl({1'b0, 1'b0, 6'd0, 1'b0, 3'd3}));
    wait_idle();
    repeat (20) @(negedge clk);
    chk(fr_cnt == 1 && cap[0][0] == 8'h20 && fr_len[0] == 68, "R13 second start ignored",
        {cap[0][0], 24'(fr_cnt)}, {8'h20, 24'd1});

    // R11 lock
    wr(A_LOCK, 32'h1);
    wr(A_MLO, 32'hFFFFFFFF);
    wr(A_TYPES, 32'h0);
    wr(A_PRE, 32'hAA);
    rd(A_MLO, s);
    chk(s == 32'h06050203, "R11 menu locked", s, 32'h06050203);
    rd(A_TYPES, s);
    chk(s == {16'h0, TYPES}, "R11 types locked", s, {16'h0, TYPES});
    rd(A_PRE, s);
    chk(s == 32'h06, "R11 prefix locked", s, 32'h06);
    fr_cnt = 0;
    wr(A_STS, 32'h6);
    wr(A_CTRL, ctl({1'b0, 1'b0, 6'd0, 1'b1, 3'd0}));
    wait_idle();
    chk(fr_cnt == 1 && cap[0][0] == 8'h03 && fr_len[0] == 5, "R11 locked cycle uses old entry",
        {cap[0][0], 24'(fr_len[0])}, {8'h03, 24'd5});

    // reset releases the lock
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(A_STS, s);
    chk(s == 0 && cs_n, "R1 status after second reset", s, 32'h0);
    wr(A_MLO, 32'h11223344);
    rd(A_MLO, s);
    chk(s == 32'h11223344, "R11 lock cleared by reset", s, 32'h11223344);

    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule